// File: doc/BRIEF.md
# Serial measurement status reader

This block takes a snapshot of a measurement engine's state and presents it to a host as a serial bit stream. On an active-high strobe it captures a 24-bit word. The word holds a 16-bit reference count and an eight-bit status byte. The status byte carries two trigger flags, frequency under-range and over-range, a count overflow flag, the lock-detector output, and the counter's running and ready flags. After the strobe, each cycle with the shift enable high moves the word one position toward the serial output.

The status byte depends on the measurement mode. When the mode select shows frequency-control mode, the lock-detector bit in the captured word is forced to zero. The host therefore cannot see the lock detector in that mode. Inputs are sampled only at the strobe, so the host reads a consistent word even while the sources keep changing.

Top module: `status_shift_reader`

## Requirements
- R1: After reset, the 24-bit shift word is all zeros and the serial output is 0.
- R2: A strobe loads the word {ready, running, lock, overflow, over_range, under_range, trig1, trig0, count[15:0]} with bit 23 on the left. The serial output shows bit 23 in the cycle that follows the strobe edge.
- R3: Each cycle with the shift enable high and no strobe moves the word left by one. The serial output then shows the next lower bit of the captured word.
- R4: Zeros enter at the low end. After 24 or more shifts the serial output is 0 until the next strobe.
- R5: When freq_mode_i is 1 (frequency-control mode), the lock bit (word bit 21) is captured as 0. When freq_mode_i is 0, it is captured from lock_i.
- R6: If the strobe and the shift enable are both high in the same cycle, the load takes priority and no shift happens.
- R7: Input changes between strobes do not affect the word being shifted out.
- R8: With neither the strobe nor the shift enable high, the word and the serial output hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_count_i | input | 16 | Reference count value |
| overflow_i | input | 1 | Reference count overflow flag |
| trig_i | input | 2 | Trigger status flags |
| under_range_i | input | 1 | Frequency under-range flag |
| over_range_i | input | 1 | Frequency over-range flag |
| lock_i | input | 1 | Lock detector output |
| running_i | input | 1 | Counter running flag |
| ready_i | input | 1 | Counter ready flag |
| freq_mode_i | input | 1 | 1 = frequency-control mode, which masks the lock bit |
| strobe_i | input | 1 | Capture strobe, active high |
| shift_en_i | input | 1 | Shift enable, one bit per high cycle |
| sdata_o | output | 1 | Serial data, MSB of the shift word |

## Verification
Any fault in the shift register shows on sdata_o at the first shift that reaches the bad position. So a strobe followed by 24 shifts exposes every bit of the word within 25 cycles. A wrong capture mapping or a wrong lock mask appears as a wrong bit in a fixed slot of the stream. A lost priority between strobe and shift appears as a missing bit 23. Late sampling of the inputs shows up as stream bits that follow input changes made during the read.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
  localparam int unsigned CNT_W  = 16;
  localparam int unsigned STAT_W = 8;
  localparam int unsigned WORD_W = CNT_W + STAT_W;

  typedef struct packed {
    logic       ready;
    logic       running;
    logic       lock;
    logic       overflow;
    logic       over_range;
    logic       under_range;
    logic [1:0] trig;
  } stat_t;
endpackage

// File: rtl/ssr_stat_pack.sv
module ssr_stat_pack
  import ssr_pkg::*;
(
  input  logic       overflow_i,
  input  logic [1:0] trig_i,
  input  logic       under_range_i,
  input  logic       over_range_i,
  input  logic       lock_i,
  input  logic       running_i,
  input  logic       ready_i,
  input  logic       freq_mode_i,
  output stat_t      stat_o
);
  always_comb begin
    stat_o.ready       = ready_i;
    stat_o.running     = running_i;
    stat_o.lock        = lock_i & ~freq_mode_i;  // masked in freq-control mode
    stat_o.overflow    = overflow_i;
    stat_o.over_range  = over_range_i;
    stat_o.under_range = under_range_i;
    stat_o.trig        = trig_i;
  end
endmodule

// File: rtl/ssr_piso.sv
module ssr_piso #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         shift_i,
  input  logic [W-1:0] par_i,
  input  logic         ser_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_o <= '0;
    else if (load_i)  q_o <= par_i;
    else if (shift_i) q_o <= {q_o[W-2:0], ser_i};
  end
endmodule

// File: rtl/status_shift_reader.sv
module status_shift_reader
  import ssr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] ref_count_i,
  input  logic             overflow_i,
  input  logic [1:0]       trig_i,
  input  logic             under_range_i,
  input  logic             over_range_i,
  input  logic             lock_i,
  input  logic             running_i,
  input  logic             ready_i,
  input  logic             freq_mode_i,
  input  logic             strobe_i,
  input  logic             shift_en_i,
  output logic             sdata_o
);
  localparam int unsigned STAGE_W = 8;
  localparam int unsigned N_STAGE = WORD_W / STAGE_W;

  stat_t             stat;
  logic [WORD_W-1:0] par_word;
  logic [WORD_W-1:0] word_q;
  logic [N_STAGE:0]  chain;

  ssr_stat_pack u_pack (
    .overflow_i   (overflow_i),
    .trig_i       (trig_i),
    .under_range_i(under_range_i),
    .over_range_i (over_range_i),
    .lock_i       (lock_i),
    .running_i    (running_i),
    .ready_i      (ready_i),
    .freq_mode_i  (freq_mode_i),
    .stat_o       (stat)
  );

  assign par_word = {stat, ref_count_i};
  assign chain[0] = 1'b0;

  // cascaded byte stages, stage 0 holds the LSB byte
  for (genvar g = 0; g < N_STAGE; g++) begin : g_stage
    ssr_piso #(.W(STAGE_W)) u_stage (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (strobe_i),
      .shift_i(shift_en_i),
      .par_i  (par_word[g*STAGE_W +: STAGE_W]),
      .ser_i  (chain[g]),
      .q_o    (word_q[g*STAGE_W +: STAGE_W])
    );
    assign chain[g+1] = word_q[g*STAGE_W + STAGE_W - 1];
  end

  assign sdata_o = chain[N_STAGE];
endmodule

// File: rtl/ssr_checker.sv
module ssr_checker
  import ssr_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              strobe_i,
  input logic              shift_en_i,
  input logic              freq_mode_i,
  input logic              lock_i,
  input logic              ready_i,
  input logic [WORD_W-1:0] word_q,
  input logic              sdata_o
);
  p_lock_mask_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && freq_mode_i) |=> (word_q[21] == 1'b0));
  p_load_prio_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i |=> (sdata_o == $past(ready_i)));
  p_shift_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!strobe_i && shift_en_i) |=> (word_q == {$past(word_q[WORD_W-2:0]), 1'b0}));
  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!strobe_i && !shift_en_i) |=> $stable(word_q));
  p_zero_fill_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!strobe_i && shift_en_i) |=> (word_q[0] == 1'b0));
  p_lock_pass_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && !freq_mode_i) |=> (word_q[21] == $past(lock_i)));
endmodule

bind status_shift_reader ssr_checker u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .strobe_i   (strobe_i),
  .shift_en_i (shift_en_i),
  .freq_mode_i(freq_mode_i),
  .lock_i     (lock_i),
  .ready_i    (ready_i),
  .word_q     (word_q),
  .sdata_o    (sdata_o)
);

// File: tb/tb_status_shift_reader.sv
`timescale 1ns/1ps
module tb_status_shift_reader;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] cnt = 0;
  logic        ovf = 0, ur = 0, orr = 0, lck = 0, run = 0, rdy = 0, fm = 0;
  logic [1:0]  trg = 0;
  logic        stb = 0, sh = 0;
  logic        sd;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  status_shift_reader dut (
    .clk_i(clk), .rst_ni(rst_n), .ref_count_i(cnt), .overflow_i(ovf),
    .trig_i(trg), .under_range_i(ur), .over_range_i(orr), .lock_i(lck),
    .running_i(run), .ready_i(rdy), .freq_mode_i(fm), .strobe_i(stb),
    .shift_en_i(sh), .sdata_o(sd)
  );

  task automatic chk(input string r, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0b exp=%0b t=%0t", r, act, exp, $time);
    end
  endtask

  function automatic logic [23:0] mkword(input logic [15:0] c, input logic [7:0] s, input logic m);
    logic [7:0] st = s;
    if (m) st[5] = 1'b0;
    return {st, c};
  endfunction

  task automatic drive_in(input logic [15:0] c, input logic [7:0] s, input logic m);
    cnt = c; {rdy, run, lck, ovf, orr, ur, trg} = s; fm = m;
  endtask

  // strobe, then read 24 bits; optionally scramble inputs while shifting
  task automatic read_word(input logic [23:0] exp, input bit scramble, input string r);
    @(negedge clk); stb = 1; sh = 0;
    @(negedge clk); stb = 0;
    for (int i = 23; i >= 0; i--) begin
      chk(r, sd, exp[i]);
      if (scramble) drive_in(~cnt, 8'hA5 ^ {rdy, run, lck, ovf, orr, ur, trg}, ~fm);
      sh = 1;
      @(negedge clk); sh = 0;
    end
    chk("R4", sd, 1'b0);
    sh = 1; @(negedge clk); sh = 0;
    chk("R4", sd, 1'b0);
  endtask

  initial begin
    #1000000;
    fails++; $display("FAIL watchdog");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1; chk("R1", sd, 1'b0);
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk); chk("R1", sd, 1'b0);

    // R2 R3 R5: sweep status bytes and both modes
    for (int s = 0; s < 256; s++) begin
      for (int m = 0; m < 2; m++) begin
        logic [15:0] c = 16'(s * 16'h9E37 + m * 16'h1234);
        drive_in(c, 8'(s), m[0]);
        read_word(mkword(c, 8'(s), m[0]), 0, m ? "R5" : "R2_R3");
      end
    end

    // R7: inputs changed during shifting
    for (int k = 0; k < 8; k++) begin
      logic [15:0] c = 16'(16'hF00D ^ (k * 16'h1111));
      drive_in(c, 8'(8'h3C + k*37), k[0]);
      read_word(mkword(c, 8'(8'h3C + k*37), k[0]), 1, "R7");
    end

    // R8: hold, then R6: strobe and shift together
    drive_in(16'h8001, 8'hFF, 0);
    @(negedge clk); stb = 1;
    @(negedge clk); stb = 0;
    repeat (5) begin @(negedge clk); chk("R8", sd, 1'b1); end
    sh = 1; @(negedge clk); sh = 0;
    chk("R3", sd, 1'b1);
    drive_in(16'h0000, 8'h40, 0);
    stb = 1; sh = 1;
    @(negedge clk); stb = 0; sh = 0;
    chk("R6", sd, 1'b0);
    sh = 1; @(negedge clk); sh = 0;
    chk("R6", sd, 1'b1);
    sh = 1; @(negedge clk); sh = 0;
    chk("R6", sd, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule